// File: doc/BRIEF.md
# Multi-Slot Conversion Start Sequencer

This block schedules conversions for a set of start-of-conversion slots that share one analog-to-digital converter. Each slot carries three static settings: the converter input channel it samples, the length of its acquisition window, and which external trigger line starts it. A slot can also be started by software through a one-cycle force strobe with a slot mask. A 2-bit feedback select per slot lets one of two interrupt lines start it, in addition to its trigger. Feeding the end-of-conversion pulses of two slot groups back on those lines therefore gives self-sustaining ping-pong conversion.

Requests are latched as pending bits. The sequencer hands pending slots to the converter one at a time, in round-robin order. For each slot it opens a sample window and then counts a fixed conversion time. At the end it captures the converter data into that slot's result register and pulses that slot's end-of-conversion line. The converter is modelled outside the block as a fixed-latency stub: the block counts the conversion time and samples `adc_data` on the last cycle.

All pins are plain control and status signals. The result is announced by a single-cycle pulse and is held in a register, so there is no back-pressure. A consumer that misses the pulse reads the slot's register through `rd_slot`/`rd_data`.

Top module: `soc_sequencer`

## Requirements
- R1: After reset, `conv_sample`, `conv_active` and `eoc` are low, and every result register reads 0.
- R2: A granted slot's sample window (`conv_sample` high) lasts its acquisition value plus one cycles. For the whole window, `conv_chan` equals that slot's channel setting.
- R3: The conversion phase (`conv_active` high) follows the window directly and lasts 13 cycles. The slot's `eoc` bit rises acquisition + 14 cycles after its window opened. The next pending slot's window opens in the same cycle as that `eoc`, with no gap, so six slots with acquisition 6 finish 120 cycles after the first window opens.
- R4: A trigger select value v in 1..N_TRIG picks `trig_in[v-1]`; the value 0 picks no trigger. A single trigger pulse makes every slot that selects it pending, and those slots convert back to back.
- R5: Feedback select encoding per slot: 0 means no feedback, 1 means `irq_line[0]` starts the slot, 2 means `irq_line[1]` starts it, and 3 means no feedback.
- R6: Trigger, feedback and force requests are OR'd. A slot whose feedback select names a line that never pulses is not started by that setting.
- R7: A one-cycle `force_wr` makes pending every slot whose bit is set in `force_mask`. When the converter is idle, the first window opens in the cycle after the one in which the force was sampled.
- R8: Pending slots are granted in ascending order, starting from the slot after the last one granted and wrapping at the top. After reset the search starts at slot 0.
- R9: A request for a slot that is already pending merges into that request and does not cause a second conversion.
- R10: `eoc` is one-hot or zero, and each bit is high for one cycle. In that cycle `res_data` shows the captured value, and the slot's result register (read combinationally as `rd_data` at `rd_slot`) holds it.
- R11: When `eoc[6]` drives `irq_line[0]`, `eoc[14]` drives `irq_line[1]`, slots 0..7 select feedback 2 and slots 8..15 select feedback 1, a force of slots 0..7 yields the endless slot sequence 0,1,...,15,0,1,....
- R12: At most one conversion is in progress: `conv_sample` and `conv_active` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan | input | N_SLOTS*CH_W | Per-slot channel select, slot i at bits [i*CH_W +: CH_W] |
| cfg_acq | input | N_SLOTS*ACQ_W | Per-slot acquisition value (window = value + 1 cycles) |
| cfg_trig | input | N_SLOTS*TSEL_W | Per-slot trigger select (0 none, v picks trig_in[v-1]) |
| cfg_fb | input | N_SLOTS*2 | Per-slot feedback select (0 none, 1 line 0, 2 line 1, 3 none) |
| trig_in | input | N_TRIG | External trigger pulses |
| irq_line | input | 2 | Interrupt feedback lines |
| force_wr | input | 1 | Software force strobe |
| force_mask | input | N_SLOTS | Slots to force when force_wr is high |
| adc_data | input | RES_W | Converter stub output, sampled on the last conversion cycle |
| conv_chan | output | CH_W | Channel select to the converter |
| conv_sample | output | 1 | Sample window open |
| conv_active | output | 1 | Conversion phase in progress |
| eoc | output | N_SLOTS | Per-slot end-of-conversion pulse |
| res_data | output | RES_W | Value written in the current eoc cycle |
| rd_slot | input | SLOT_W | Result register read index |
| rd_data | output | RES_W | Result register at rd_slot |

## Verification
A corrupted pending bit shows up as a missing or extra `eoc` in the next burst, within one slot time of the request. A wrong round-robin pointer shows up as an out-of-order `eoc` sequence on the first grant after it goes wrong. A miscounted phase timer moves the `conv_sample` fall or the `eoc` rise by whole cycles, so comparing each `eoc` cycle with the running sum of acquisition + 14 exposes it on the first slot affected. A result written to the wrong register is exposed by comparing `res_data` and the `rd_data` read-back with the stub value of the slot's channel.

// File: rtl/soc_seq_pkg.sv
package soc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

  localparam logic [1:0] FB_NONE  = 2'd0;
  localparam logic [1:0] FB_LINE0 = 2'd1;
  localparam logic [1:0] FB_LINE1 = 2'd2;
endpackage

// File: rtl/soc_req_latch.sv
module soc_req_latch #(
  parameter int N_SLOTS = 16,
  parameter int N_TRIG  = 8,
  parameter int TSEL_W  = 4,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SLOTS*TSEL_W-1:0] cfg_trig,
  input  logic [N_SLOTS*2-1:0]      cfg_fb,
  input  logic [N_TRIG-1:0]         trig_in,
  input  logic [1:0]                irq_line,
  input  logic                      force_wr,
  input  logic [N_SLOTS-1:0]        force_mask,
  input  logic                      clr_en,
  input  logic [SLOT_W-1:0]         clr_idx,
  output logic [N_SLOTS-1:0]        pending
);
  import soc_seq_pkg::*;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [TSEL_W-1:0] tsel;
    logic [1:0]        fsel;
    logic              trig_hit;
    logic              fb_hit;
    logic              req;
    logic              clr;

    assign tsel = cfg_trig[s*TSEL_W +: TSEL_W];
    assign fsel = cfg_fb[s*2 +: 2];

    always_comb begin
      trig_hit = 1'b0;
      for (int t = 0; t < N_TRIG; t++) begin
        if (tsel == TSEL_W'(t + 1)) trig_hit = trig_hit | trig_in[t];
      end
    end

    assign fb_hit = ((fsel == FB_LINE0) && irq_line[0]) ||
                    ((fsel == FB_LINE1) && irq_line[1]);
    assign req    = trig_hit || fb_hit || (force_wr && force_mask[s]);
    assign clr    = clr_en && (clr_idx == SLOT_W'(s));

    // a request arriving with the grant wins, so it is not lost
    always_ff @(posedge clk) begin
      if (!rst_n) pending[s] <= 1'b0;
      else        pending[s] <= (pending[s] && !clr) || req;
    end
  end
endmodule

// File: rtl/soc_rr_pick.sv
module soc_rr_pick #(
  parameter int N_SLOTS = 16,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] pending,
  input  logic [SLOT_W-1:0]  last_idx,
  output logic               any,
  output logic [SLOT_W-1:0]  sel
);
  always_comb begin
    any = |pending;
    sel = '0;
    // scan from the far end so the nearest pending slot is assigned last
    for (int k = N_SLOTS - 1; k >= 0; k--) begin
      int j;
      j = (int'(last_idx) + 1 + k) % N_SLOTS;
      if (pending[j]) sel = SLOT_W'(j);
    end
  end
endmodule

// File: rtl/soc_conv_timer.sv
module soc_conv_timer #(
  parameter int ACQ_W    = 6,
  parameter int CONV_CYC = 13,
  localparam int CONV_W  = $clog2(CONV_CYC),
  localparam int CNT_W   = (ACQ_W > CONV_W) ? ACQ_W : CONV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [ACQ_W-1:0] acq_in,
  output logic             take,
  output logic             finish,
  output logic             sampling,
  output logic             converting
);
  import soc_seq_pkg::*;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign finish     = (state == ST_CONVERT) && (cnt == '0);
  assign take       = go && ((state == ST_IDLE) || finish);
  assign sampling   = (state == ST_SAMPLE);
  assign converting = (state == ST_CONVERT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (take) begin
      state <= ST_SAMPLE;
      cnt   <= CNT_W'(acq_in);
    end else begin
      unique case (state)
        ST_SAMPLE: begin
          if (cnt == '0) begin
            state <= ST_CONVERT;
            cnt   <= CNT_W'(CONV_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONVERT: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/soc_result_bank.sv
module soc_result_bank #(
  parameter int N_SLOTS = 16,
  parameter int RES_W   = 12,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_idx,
  input  logic [RES_W-1:0]   wr_data,
  input  logic [SLOT_W-1:0]  rd_idx,
  output logic [RES_W-1:0]   rd_data,
  output logic [N_SLOTS-1:0] eoc,
  output logic [RES_W-1:0]   last_data
);
  logic [RES_W-1:0] store [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        store[s] <= '0;
        eoc[s]   <= 1'b0;
      end else begin
        eoc[s] <= wr_en && (wr_idx == SLOT_W'(s));
        if (wr_en && (wr_idx == SLOT_W'(s))) store[s] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_data <= '0;
    else if (wr_en) last_data <= wr_data;
  end

  assign rd_data = store[rd_idx];
endmodule

// File: rtl/soc_sequencer.sv
module soc_sequencer #(
  parameter int N_SLOTS  = 16,
  parameter int N_TRIG   = 8,
  parameter int CH_W     = 4,
  parameter int ACQ_W    = 6,
  parameter int TSEL_W   = 4,
  parameter int RES_W    = 12,
  parameter int CONV_CYC = 13,
  localparam int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SLOTS*CH_W-1:0]   cfg_chan,
  input  logic [N_SLOTS*ACQ_W-1:0]  cfg_acq,
  input  logic [N_SLOTS*TSEL_W-1:0] cfg_trig,
  input  logic [N_SLOTS*2-1:0]      cfg_fb,
  input  logic [N_TRIG-1:0]         trig_in,
  input  logic [1:0]                irq_line,
  input  logic                      force_wr,
  input  logic [N_SLOTS-1:0]        force_mask,
  input  logic [RES_W-1:0]          adc_data,
  output logic [CH_W-1:0]           conv_chan,
  output logic                      conv_sample,
  output logic                      conv_active,
  output logic [N_SLOTS-1:0]        eoc,
  output logic [RES_W-1:0]          res_data,
  input  logic [SLOT_W-1:0]         rd_slot,
  output logic [RES_W-1:0]          rd_data
);
  logic [N_SLOTS-1:0] pending;
  logic               any_pend;
  logic [SLOT_W-1:0]  next_slot;
  logic [SLOT_W-1:0]  cur_slot;
  logic               take;
  logic               finish;

  soc_req_latch #(
    .N_SLOTS(N_SLOTS), .N_TRIG(N_TRIG), .TSEL_W(TSEL_W)
  ) u_req (
    .clk(clk), .rst_n(rst_n),
    .cfg_trig(cfg_trig), .cfg_fb(cfg_fb),
    .trig_in(trig_in), .irq_line(irq_line),
    .force_wr(force_wr), .force_mask(force_mask),
    .clr_en(take), .clr_idx(next_slot),
    .pending(pending)
  );

  soc_rr_pick #(.N_SLOTS(N_SLOTS)) u_pick (
    .pending(pending), .last_idx(cur_slot),
    .any(any_pend), .sel(next_slot)
  );

  soc_conv_timer #(.ACQ_W(ACQ_W), .CONV_CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .go(any_pend),
    .acq_in(cfg_acq[next_slot*ACQ_W +: ACQ_W]),
    .take(take), .finish(finish),
    .sampling(conv_sample), .converting(conv_active)
  );

  // cur_slot doubles as the round-robin pointer; reset value makes slot 0 first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_slot  <= SLOT_W'(N_SLOTS - 1);
      conv_chan <= '0;
    end else if (take) begin
      cur_slot  <= next_slot;
      conv_chan <= cfg_chan[next_slot*CH_W +: CH_W];
    end
  end

  soc_result_bank #(.N_SLOTS(N_SLOTS), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(finish), .wr_idx(cur_slot), .wr_data(adc_data),
    .rd_idx(rd_slot), .rd_data(rd_data),
    .eoc(eoc), .last_data(res_data)
  );
endmodule

// File: rtl/soc_sequencer_chk.sv
module soc_sequencer_chk #(
  parameter int N_SLOTS = 16,
  parameter int CH_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               conv_sample,
  input logic               conv_active,
  input logic [CH_W-1:0]    conv_chan,
  input logic [N_SLOTS-1:0] eoc
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_sample && conv_active));

  p_eoc_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoc));

  p_eoc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoc) |=> ((eoc & $past(eoc)) == '0));

  p_eoc_after_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|eoc) |-> $past(conv_active));

  p_sample_then_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_sample) && !(|eoc) |-> conv_active);

  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_sample && $past(conv_sample) |-> $stable(conv_chan));
endmodule

bind soc_sequencer soc_sequencer_chk #(.N_SLOTS(N_SLOTS), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_sample(conv_sample),
  .conv_active(conv_active), .conv_chan(conv_chan), .eoc(eoc)
);

// File: tb/soc_sequencer_tb_top.sv
module soc_sequencer_tb_top;
  localparam int N = 16;
  localparam int NT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [3:0] chan_a [N];
  logic [5:0] acq_a  [N];
  logic [3:0] tsel_a [N];
  logic [1:0] fb_a   [N];
  logic [11:0] ana   [N];
  logic [N*4-1:0] cfg_chan, cfg_trig;
  logic [N*6-1:0] cfg_acq;
  logic [N*2-1:0] cfg_fb;
  logic [NT-1:0]  trig_in;
  logic [1:0]     irq_man, irq_line;
  logic           pp_en, force_wr;
  logic [N-1:0]   force_mask, eoc;
  logic [11:0]    adc_data, res_data, rd_data;
  logic [3:0]     conv_chan, rd_slot;
  logic           conv_sample, conv_active;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_chan[i*4 +: 4] = chan_a[i];
      cfg_acq[i*6 +: 6]  = acq_a[i];
      cfg_trig[i*4 +: 4] = tsel_a[i];
      cfg_fb[i*2 +: 2]   = fb_a[i];
    end
  end
  assign adc_data = ana[conv_chan];
  assign irq_line = pp_en ? {eoc[14], eoc[6]} : irq_man;

  soc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_acq(cfg_acq),
    .cfg_trig(cfg_trig), .cfg_fb(cfg_fb), .trig_in(trig_in),
    .irq_line(irq_line), .force_wr(force_wr), .force_mask(force_mask),
    .adc_data(adc_data), .conv_chan(conv_chan), .conv_sample(conv_sample),
    .conv_active(conv_active), .eoc(eoc), .res_data(res_data),
    .rd_slot(rd_slot), .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0, last_slot = N - 1;
  int both_err = 0, multi_err = 0, s_len = 0;
  logic prev_s = 1'b0;
  int ev_slot[$], ev_cyc[$], ev_data[$], starts[$], lens[$], lchan[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_sample && !prev_s) begin starts.push_back(cyc); s_len = 1; end
      else if (conv_sample) s_len++;
      if (prev_s && !conv_sample) begin lens.push_back(s_len); lchan.push_back(int'(conv_chan)); end
      if (|eoc) begin
        for (int i = 0; i < N; i++) if (eoc[i]) ev_slot.push_back(i);
        ev_cyc.push_back(cyc);
        ev_data.push_back(int'(res_data));
        if ($countones(eoc) > 1) multi_err++;
      end
      if (conv_sample && conv_active) both_err++;
      prev_s = conv_sample;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    ev_slot.delete(); ev_cyc.delete(); ev_data.delete();
    starts.delete(); lens.delete(); lchan.delete();
  endtask

  task automatic cfg_clear();
    for (int i = 0; i < N; i++) begin
      tsel_a[i] = 4'd0; fb_a[i] = 2'd0; acq_a[i] = 6'd6;
      chan_a[i] = 4'($urandom_range(0, 15));
      ana[i] = 12'($urandom);
    end
  endtask

  task automatic wait_idle();
    int idle = 0, guard = 0;
    while (idle < 4 && guard < 20000) begin
      @(negedge clk);
      if (!conv_sample && !conv_active) idle++; else idle = 0;
      guard++;
    end
  endtask

  task automatic pulse_trig(input int t);
    @(negedge clk) trig_in[t] = 1'b1;
    @(negedge clk) trig_in[t] = 1'b0;
  endtask

  task automatic pulse_irq(input logic [1:0] v);
    @(negedge clk) irq_man = v;
    @(negedge clk) irq_man = 2'b00;
  endtask

  task automatic do_force(input logic [N-1:0] m, output int cf);
    @(negedge clk); force_mask = m; force_wr = 1'b1;
    @(negedge clk); cf = cyc; force_wr = 1'b0;
  endtask

  function automatic void exp_order(input logic [N-1:0] m, input int last, ref int q[$]);
    q.delete();
    for (int k = 1; k <= N; k++) if (m[(last + k) % N]) q.push_back((last + k) % N);
  endfunction

  // compares a back-to-back burst against order, window, timing and data rules
  task automatic check_run(input int q[$], input bit timed);
    int t;
    chk(ev_slot.size() == q.size(), "R4 eoc count", ev_slot.size(), q.size());
    if (ev_slot.size() == q.size() && q.size() > 0 && starts.size() > 0) begin
      t = starts[0];
      for (int k = 0; k < q.size(); k++) begin
        int s;
        s = q[k];
        chk(ev_slot[k] == s, "R8 grant order", ev_slot[k], s);
        chk(ev_data[k] == int'(ana[chan_a[s]]), "R10 result value", ev_data[k], int'(ana[chan_a[s]]));
        if (k < lens.size()) begin
          chk(lens[k] == int'(acq_a[s]) + 1, "R2 window length", lens[k], int'(acq_a[s]) + 1);
          chk(lchan[k] == int'(chan_a[s]), "R2 channel", lchan[k], int'(chan_a[s]));
        end
        if (timed) begin
          t += int'(acq_a[s]) + 14;
          chk(ev_cyc[k] == t, "R3 eoc cycle", ev_cyc[k], t);
        end
      end
      last_slot = q[q.size() - 1];
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int q[$];
    int cf;
    void'($urandom(32'd1234));
    rst_n = 1'b0; trig_in = '0; irq_man = '0; pp_en = 1'b0;
    force_wr = 1'b0; force_mask = '0; rd_slot = '0;
    cfg_clear();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!conv_sample && !conv_active, "R1 idle in reset", int'(conv_sample | conv_active), 0);
    chk(eoc == '0, "R1 eoc in reset", int'(eoc), 0);
    rd_slot = 4'd3; #1;
    chk(rd_data == '0, "R1 result reset", int'(rd_data), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4/R3: shared trigger on six slots, acquisition 6
    clear_ev();
    for (int i = 0; i < 6; i++) tsel_a[i] = 4'd1;
    pulse_trig(0);
    wait_idle();
    exp_order(16'h003F, last_slot, q);
    check_run(q, 1'b1);
    if (ev_cyc.size() == 6 && starts.size() > 0)
      chk(ev_cyc[5] - starts[0] == 120, "R3 six slots 120 cycles", ev_cyc[5] - starts[0], 120);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) rd_slot = 4'(i); #1;
      chk(rd_data == ana[chan_a[i]], "R10 register read", int'(rd_data), int'(ana[chan_a[i]]));
    end

    // R7/R8: force slots 0..7 with pointer at 5
    cfg_clear(); clear_ev();
    do_force(16'h00FF, cf);
    wait_idle();
    if (starts.size() > 0) chk(starts[0] == cf + 1, "R7 force latency", starts[0], cf + 1);
    exp_order(16'h00FF, last_slot, q);
    check_run(q, 1'b1);

    // R9: repeated trigger on a pending slot merges
    cfg_clear(); clear_ev();
    acq_a[0] = 6'd40; tsel_a[2] = 4'd2;
    do_force(16'h0001, cf);
    repeat (6) @(negedge clk);
    pulse_trig(1); pulse_trig(1); pulse_trig(1);
    wait_idle();
    chk(ev_slot.size() == 2, "R9 merged count", ev_slot.size(), 2);
    exp_order(16'h0005, last_slot, q);
    check_run(q, 1'b0);

    // R5/R6: feedback encoding and OR with trigger
    cfg_clear();
    fb_a[9] = 2'd1; tsel_a[9] = 4'd3; fb_a[10] = 2'd2; fb_a[11] = 2'd0; fb_a[12] = 2'd3;
    clear_ev(); pulse_irq(2'b01); wait_idle();
    exp_order(16'h0200, last_slot, q); check_run(q, 1'b1);
    chk(ev_slot.size() == 1, "R5 line 0 starts only select 1", ev_slot.size(), 1);
    clear_ev(); pulse_irq(2'b10); wait_idle();
    exp_order(16'h0400, last_slot, q); check_run(q, 1'b1);
    chk(ev_slot.size() == 1, "R5 line 1 starts only select 2", ev_slot.size(), 1);
    clear_ev(); pulse_trig(2); wait_idle();
    exp_order(16'h0200, last_slot, q); check_run(q, 1'b1);
    chk(ev_slot.size() == 1, "R6 trigger OR feedback", ev_slot.size(), 1);
    clear_ev(); repeat (60) @(negedge clk);
    chk(ev_slot.size() == 0, "R6 silent line no start", ev_slot.size(), 0);

    // R11: ping-pong via eoc feedback
    cfg_clear(); clear_ev();
    for (int i = 0; i < N; i++) begin fb_a[i] = (i < 8) ? 2'd2 : 2'd1; acq_a[i] = 6'd1; end
    pp_en = 1'b1;
    do_force(16'h00FF, cf);
    for (int g = 0; g < 4000 && ev_slot.size() < 48; g++) @(negedge clk);
    pp_en = 1'b0;
    wait_idle();
    chk(ev_slot.size() >= 48, "R11 ping-pong sustained", ev_slot.size(), 48);
    if (ev_slot.size() >= 48)
      for (int k = 0; k < 48; k++) chk(ev_slot[k] == k % 16, "R11 ping-pong order", ev_slot[k], k % 16);
    last_slot = ev_slot.size() > 0 ? ev_slot[ev_slot.size() - 1] : last_slot;

    // random forced bursts
    for (int it = 0; it < 20; it++) begin
      logic [N-1:0] m;
      cfg_clear(); clear_ev();
      for (int i = 0; i < N; i++) acq_a[i] = 6'($urandom_range(0, 20));
      m = N'($urandom) | (N'(1) << $urandom_range(0, N - 1));
      do_force(m, cf);
      wait_idle();
      exp_order(m, last_slot, q);
      check_run(q, 1'b1);
    end

    chk(both_err == 0, "R12 exclusive phases", both_err, 0);
    chk(multi_err == 0, "R10 eoc one-hot", multi_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule